// File: doc/BRIEF.md
# Hex Status Code Pixel Renderer

This block turns a 32-bit status code into pixels. The code is shown as a row of eight hexadecimal characters on a monochrome screen. A display scanner asks for one screen coordinate at a time. One cycle later the block answers with a single on/off pixel and a valid flag. A load strobe captures the code into an internal holding register. The code input can then change freely without tearing a frame that is already being scanned.

The characters come from a glyph store that is built at elaboration. It holds sixteen 9-wide by 18-tall seven-segment shapes. Each glyph row takes two bytes. The block finds which character cell a coordinate falls in and selects the nibble for that cell. It then reads the glyph row and extracts the one pixel bit. Everything outside the text box is background.

Top module: `hexr_pixel_gen`

## Requirements
- R1: Reset is asynchronous and active low. While reset is applied, and in the first cycle after it, `pix_valid` and `pix_on` are 0. The held code resets to 0x00000000, so before any load every character draws the glyph for 0.
- R2: The held code takes the value of `code_in` at a rising edge where `code_load` is 1. At every other edge the held code keeps its value, and changes on `code_in` have no effect on the rendered pixels.
- R3: `req_valid` sampled at a rising edge appears on `pix_valid` right after that same edge, one cycle of latency. `pix_on` is 0 whenever `pix_valid` is 0.
- R4: The text box spans x from 28 to 115 inclusive and y from 116 to 133 inclusive. Any coordinate outside it gives `pix_on` = 0.
- R5: Inside the box, with dx = x-28, the character slot is s = dx/11. Slot s shows nibble 7-s, taken from code bits [4(7-s)+3 : 4(7-s)]. Slot 0, the leftmost, therefore shows bits 31:28.
- R6: Within a slot the cell column is c = dx mod 11. Columns 9 and 10 are spacing and always give 0.
- R7: Within a glyph, with row r = y-116 and column c from 0 to 8, the segments are lit as follows. Segment a covers r 0..1, every column. Segment g covers r 8..9. Segment d covers r 16..17. Segment f covers c 0..1 for r 0..9, and segment b covers c 7..8 for r 0..9. Segment e covers c 0..1 for r 8..17, and segment c covers c 7..8 for r 8..17. A pixel is 1 exactly when it lies in a segment that the digit enables.
- R8: The segment mask is written with bit0=a, bit1=b, bit2=c, bit3=d, bit4=e, bit5=f, bit6=g. The masks per digit are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, B=7C, C=39, D=5E, E=79, F=71 (hex).
- R9: Each glyph row is stored as two bytes. Columns 0..7 are bits 0..7 of the first byte, with the least significant bit leftmost. Column 8 is bit 0 of the second byte. Columns 0 and 8 must both render correctly, for example the full-width top bar of digit 8.
- R10: A load and a pixel request can arrive at the same rising edge. In that case the pixel is rendered from the code held before that edge. Requests from the next edge on use the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | 32 | Status code to capture |
| code_load | input | 1 | Capture strobe for `code_in` |
| req_valid | input | 1 | A coordinate request is present |
| req_x | input | 8 | Requested pixel column |
| req_y | input | 8 | Requested pixel row |
| pix_valid | output | 1 | Registered answer is present |
| pix_on | output | 1 | Registered pixel value, 1 = lit |

## Verification
Capturing a new code and rendering a pixel can happen at the same clock edge. The bench provokes this by raising `code_load` with a different code in the same cycle that it requests a pixel in slot 0. That pixel is chosen because the glyph for 0 lights it and the glyph for 1 does not. The answer must come from the old code, and a repeat of the request one cycle later must come from the new one. Between those cases, full raster scans over the box and its borders are compared against a pixel model built from the segment geometry.

// File: rtl/hexr_pkg.sv
`timescale 1ns/1ps
package hexr_pkg;

    // Glyph cell geometry (fixed by the font)
    localparam int GLYPH_W    = 9;
    localparam int GLYPH_H    = 18;
    localparam int PITCH      = 11;
    localparam int STROKE     = 2;
    localparam int NUM_GLYPHS = 16;
    localparam int ROW_BYTES  = (GLYPH_W + 7) / 8;
    localparam int ROW_BITS   = 8 * ROW_BYTES;
    localparam int ROW_W      = $clog2(GLYPH_H);
    localparam int COL_W      = $clog2(PITCH);

    typedef logic [ROW_BITS-1:0] glyph_row_t;
    typedef logic [3:0]          nibble_t;

    typedef struct packed {
        logic valid;
        logic on;
    } pix_state_t;

    // Segment enables per hex value: bit0=a (top) ... bit6=g (middle)
    function automatic logic [6:0] seg_mask(input int unsigned d);
        logic [6:0] m;
        case (d)
            0:  m = 7'h3F;
            1:  m = 7'h06;
            2:  m = 7'h5B;
            3:  m = 7'h4F;
            4:  m = 7'h66;
            5:  m = 7'h6D;
            6:  m = 7'h7D;
            7:  m = 7'h07;
            8:  m = 7'h7F;
            9:  m = 7'h6F;
            10: m = 7'h77;
            11: m = 7'h7C;
            12: m = 7'h39;
            13: m = 7'h5E;
            14: m = 7'h79;
            15: m = 7'h71;
            default: m = 7'h00;
        endcase
        return m;
    endfunction

    // Whether a cell position lies on an enabled stroke
    function automatic logic seg_hit(input logic [6:0] m, input int c, input int r);
        logic upper, lower, left, right, hit;
        upper = (r <= GLYPH_H / 2);
        lower = (r >= GLYPH_H / 2 - 1);
        left  = (c < STROKE);
        right = (c >= GLYPH_W - STROKE);
        hit   = 1'b0;
        if (m[0] && (r < STROKE))                                hit = 1'b1;
        if (m[1] && right && upper)                              hit = 1'b1;
        if (m[2] && right && lower)                              hit = 1'b1;
        if (m[3] && (r >= GLYPH_H - STROKE))                     hit = 1'b1;
        if (m[4] && left && lower)                               hit = 1'b1;
        if (m[5] && left && upper)                               hit = 1'b1;
        if (m[6] && (r >= GLYPH_H / 2 - 1) && (r <= GLYPH_H / 2)) hit = 1'b1;
        return hit;
    endfunction

    // Packs one glyph row: byte k holds columns 8k..8k+7, LSB leftmost
    function automatic glyph_row_t glyph_row(input int unsigned d, input int r);
        glyph_row_t w;
        logic [6:0] m;
        m = seg_mask(d);
        w = '0;
        for (int c = 0; c < GLYPH_W; c++) begin
            if (seg_hit(m, c, r)) w[8 * (c / 8) + (c % 8)] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/hexr_code_latch.sv
`timescale 1ns/1ps
module hexr_code_latch #(
    parameter int CODE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_load,
    output logic [CODE_W-1:0] code_q
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (code_load) st_d.code = code_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_q = st_q.code;

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !code_load |=> $stable(code_q)); // R2

    AST_CODE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        code_load |=> (code_q == $past(code_in))); // R2

endmodule

// File: rtl/hexr_locate.sv
`timescale 1ns/1ps
module hexr_locate
    import hexr_pkg::*;
#(
    parameter int X_W        = 8,
    parameter int Y_W        = 8,
    parameter int ORG_X      = 28,
    parameter int ORG_Y      = 116,
    parameter int NUM_DIGITS = 8,
    localparam int SLOT_W    = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic [X_W-1:0]    req_x,
    input  logic [Y_W-1:0]    req_y,
    output logic              in_area,
    output logic              in_glyph,
    output logic [SLOT_W-1:0] slot,
    output logic [COL_W-1:0]  col,
    output logic [ROW_W-1:0]  row
);

    localparam int AREA_W = NUM_DIGITS * PITCH;

    logic [X_W-1:0] dx_d;
    logic [Y_W-1:0] dy_d;
    logic [X_W-1:0] cell_d;
    logic           in_x_d, in_y_d;

    always_comb begin
        dx_d   = req_x - X_W'(ORG_X);
        dy_d   = req_y - Y_W'(ORG_Y);
        in_x_d = (req_x >= X_W'(ORG_X)) && (dx_d < X_W'(AREA_W));
        in_y_d = (req_y >= Y_W'(ORG_Y)) && (dy_d < Y_W'(GLYPH_H));

        // Division by the pitch as a chain of threshold compares
        slot = '0;
        for (int k = 1; k < NUM_DIGITS; k++) begin
            if (dx_d >= X_W'(k * PITCH)) slot = SLOT_W'(k);
        end
        cell_d = dx_d - X_W'(slot) * X_W'(PITCH);

        col      = COL_W'(cell_d);
        row      = ROW_W'(dy_d);
        in_area  = in_x_d && in_y_d;
        in_glyph = (cell_d < X_W'(GLYPH_W));
    end

endmodule

// File: rtl/hexr_glyph_rom.sv
`timescale 1ns/1ps
module hexr_glyph_rom
    import hexr_pkg::*;
(
    input  nibble_t          digit,
    input  logic [ROW_W-1:0] row,
    output glyph_row_t       word
);

    localparam int DEPTH = NUM_GLYPHS * GLYPH_H;
    localparam int IDX_W = $clog2(DEPTH);

    glyph_row_t rows [DEPTH];

    for (genvar g = 0; g < NUM_GLYPHS; g++) begin : g_glyph
        for (genvar r = 0; r < GLYPH_H; r++) begin : g_row
            localparam glyph_row_t ROW_VAL = glyph_row(g, r);
            assign rows[g * GLYPH_H + r] = ROW_VAL;
        end
    end

    logic [IDX_W-1:0] idx_d;

    always_comb begin
        idx_d = IDX_W'(digit) * IDX_W'(GLYPH_H) + IDX_W'(row);
        word  = '0;
        if (row < ROW_W'(GLYPH_H)) word = rows[idx_d];
    end

endmodule

// File: rtl/hexr_pixel_gen.sv
`timescale 1ns/1ps
module hexr_pixel_gen
    import hexr_pkg::*;
#(
    parameter int X_W        = 8,
    parameter int Y_W        = 8,
    parameter int ORG_X      = 28,
    parameter int ORG_Y      = 116,
    parameter int NUM_DIGITS = 8,
    localparam int CODE_W    = 4 * NUM_DIGITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_load,
    input  logic              req_valid,
    input  logic [X_W-1:0]    req_x,
    input  logic [Y_W-1:0]    req_y,
    output logic              pix_valid,
    output logic              pix_on
);

    localparam int SLOT_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

    logic [CODE_W-1:0] code_q;
    logic              loc_in_area, loc_in_glyph;
    logic [SLOT_W-1:0] loc_slot;
    logic [COL_W-1:0]  loc_col;
    logic [ROW_W-1:0]  loc_row;
    logic [SLOT_W-1:0] nib_idx_d;
    nibble_t           digit_d;
    glyph_row_t        word_d;
    logic [7:0]        byte_d;
    logic              lit_d;

    pix_state_t pix_d, pix_q;

    hexr_code_latch #(.CODE_W(CODE_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_in   (code_in),
        .code_load (code_load),
        .code_q    (code_q)
    );

    hexr_locate #(
        .X_W        (X_W),
        .Y_W        (Y_W),
        .ORG_X      (ORG_X),
        .ORG_Y      (ORG_Y),
        .NUM_DIGITS (NUM_DIGITS)
    ) u_locate (
        .req_x    (req_x),
        .req_y    (req_y),
        .in_area  (loc_in_area),
        .in_glyph (loc_in_glyph),
        .slot     (loc_slot),
        .col      (loc_col),
        .row      (loc_row)
    );

    // Leftmost slot carries the most significant nibble
    always_comb begin
        nib_idx_d = SLOT_W'(NUM_DIGITS - 1) - loc_slot;
        digit_d   = code_q[{nib_idx_d, 2'b00} +: 4];
    end

    hexr_glyph_rom u_rom (
        .digit (digit_d),
        .row   (loc_row),
        .word  (word_d)
    );

    // Byte select from the upper column bit, bit select from the lower three
    always_comb begin
        byte_d = word_d[8 * loc_col[3] +: 8];
        lit_d  = loc_in_area && loc_in_glyph && byte_d[loc_col[2:0]];

        pix_d       = pix_q;
        pix_d.valid = req_valid;
        pix_d.on    = req_valid && lit_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign pix_valid = pix_q.valid;
    assign pix_on    = pix_q.on;

    AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pix_valid); // R3

    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!pix_valid && !pix_on)); // R3

    AST_OUTSIDE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !loc_in_area) |=> !pix_on); // R4

    AST_GAP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && loc_in_area && !loc_in_glyph) |=> !pix_on); // R6

endmodule

// File: tb/sim_hexr_pixel_gen.sv
`timescale 1ns/1ps
module sim_hexr_pixel_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] code_in = '0;
    logic        code_load = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_x = '0;
    logic [7:0]  req_y = '0;
    logic        pix_valid, pix_on;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    hexr_pixel_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_in   (code_in),
        .code_load (code_load),
        .req_valid (req_valid),
        .req_x     (req_x),
        .req_y     (req_y),
        .pix_valid (pix_valid),
        .pix_on    (pix_on)
    );

    // Independent pixel model from R4..R8
    function automatic logic [6:0] mask_of(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;  10: return 7'h77; 11: return 7'h7C;
            12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    function automatic logic model(input logic [31:0] code, input int x, input int y);
        int dx, s, c, r;
        logic [6:0] m;
        if (x < 28 || x > 115 || y < 116 || y > 133) return 1'b0;
        dx = x - 28;
        s  = dx / 11;
        c  = dx % 11;
        r  = y - 116;
        if (c > 8) return 1'b0;
        m = mask_of(int'(code[4 * (7 - s) +: 4]));
        return (m[0] && r <= 1) ||
               (m[1] && c >= 7 && r <= 9) ||
               (m[2] && c >= 7 && r >= 8) ||
               (m[3] && r >= 16) ||
               (m[4] && c <= 1 && r >= 8) ||
               (m[5] && c <= 1 && r <= 9) ||
               (m[6] && (r == 8 || r == 9));
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // Drives one cycle of request; returns at the next falling edge
    task automatic drive(input logic v, input int x, input int y);
        req_valid = v;
        req_x = 8'(x);
        req_y = 8'(y);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load_code(input logic [31:0] c);
        code_in = c;
        code_load = 1'b1;
        @(negedge clk);
        code_load = 1'b0;
    endtask

    task automatic probe(input string tag, input int x, input int y, input logic exp);
        drive(1'b1, x, y);
        check(tag, $sformatf("valid at (%0d,%0d)", x, y), pix_valid, 1'b1);
        check(tag, $sformatf("pixel at (%0d,%0d)", x, y), pix_on, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "pix_valid in reset", pix_valid, 1'b0);
        check("R1", "pix_on in reset", pix_on, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "pix_valid after reset", pix_valid, 1'b0);
        check("R1", "pix_on after reset", pix_on, 1'b0);
        // Default code 0: left bar of glyph 0 lit, centre blank
        probe("R1", 28, 121, 1'b1);
        probe("R1", 32, 121, 1'b0);
    endtask

    task automatic t_valid;
        drive(1'b0, 28, 116);
        check("R3", "pix_valid idle", pix_valid, 1'b0);
        check("R3", "pix_on idle", pix_on, 1'b0);
        probe("R3", 28, 116, 1'b1);
    endtask

    task automatic t_boundary;
        load_code(32'h8888_8888);
        probe("R4", 27, 116, 1'b0);
        probe("R4", 28, 116, 1'b1);
        probe("R4", 113, 116, 1'b1);
        probe("R4", 116, 116, 1'b0);
        probe("R4", 28, 115, 1'b0);
        probe("R4", 28, 133, 1'b1);
        probe("R4", 28, 134, 1'b0);
    endtask

    task automatic t_gap;
        for (int y = 116; y < 134; y++) begin
            probe("R6", 37, y, 1'b0);
            probe("R6", 38, y, 1'b0);
            probe("R6", 114, y, 1'b0);
        end
    endtask

    task automatic t_col8;
        probe("R9", 28, 116, 1'b1);
        probe("R9", 36, 116, 1'b1);
        probe("R9", 36, 121, 1'b1);
        probe("R9", 35, 121, 1'b1);
        probe("R9", 34, 121, 1'b0);
        probe("R9", 29, 119, 1'b1);
        probe("R9", 30, 119, 1'b0);
    endtask

    // Raster scan covering slot order (R5), geometry (R7) and masks (R8)
    task automatic t_scan(input logic [31:0] code);
        load_code(code);
        for (int y = 114; y < 136; y++) begin
            for (int x = 25; x < 119; x++) begin
                drive(1'b1, x, y);
                check("R5/R7/R8", $sformatf("code %h at (%0d,%0d)", code, x, y),
                      pix_on, model(code, x, y));
            end
        end
    endtask

    task automatic t_ignore;
        load_code(32'hFFFF_FFFF);
        code_in = 32'h0000_0000;
        repeat (3) @(negedge clk);
        for (int s = 0; s < 8; s++) begin
            probe("R2", 28 + 11 * s + 4, 133, 1'b0);
            probe("R2", 28 + 11 * s, 120, 1'b1);
        end
    endtask

    task automatic t_same_edge;
        load_code(32'h0000_0000);
        code_in   = 32'h1000_0000;
        code_load = 1'b1;
        drive(1'b1, 28, 121);
        code_load = 1'b0;
        check("R10", "pixel at load edge uses old code", pix_on, 1'b1);
        probe("R10", 28, 121, 1'b0);
        probe("R10", 35, 121, 1'b1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        t_valid();
        t_boundary();
        t_gap();
        t_col8();
        t_scan(32'h0123_4567);
        t_scan(32'h89AB_CDEF);
        t_scan(32'hA5C3_E1F0);
        t_ignore();
        t_same_edge();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule